// File: doc/BRIEF.md
# SDRAM Command Sequencer with Refresh Gating

This block sits between a simple request port and the command pins of one four-bank SDRAM device. A client presents a read, write or refresh request and holds it until the block accepts it. The block turns each request into the single-cycle device commands it needs. A bank that is idle is opened with an activate. A bank that is open on a different row is precharged and then re-opened. A bank that is already open on the requested row gets the column command at once. All pin outputs are registered. Between commands the pins carry a NOP.

A refresh request first closes every open bank with one precharge-all and waits tRP. It then issues the auto refresh. For tRC cycles after the refresh the pins carry nothing but NOPs. The burst length is one word. Write data goes out on the cycle of the write command. Read data is captured from the device CAS latency cycles after the read and is handed to the client with a valid strobe. The CAS latency, tRP, tRCD and tRC are parameters.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is active the pins hold a deselect ({cs_n,ras_n,cas_n,we_n}=1111) with CKE low. After reset CKE is high and every idle cycle is a NOP (0111). The other codes are activate 0011, read 0101, write 0100, precharge 0010 and refresh 0001.
- R2: A write puts its data on sd_dq_out with sd_dq_oe high in the same cycle as the write command. The column sits on sd_addr[COL_W-1:0] with sd_addr[10] low, and reads use the same address layout.
- R3: When a read command is on the pins in cycle c, rd_valid is high in cycle c+CL+1. In that cycle rd_data holds the sd_dq_in value sampled at the end of cycle c+CL.
- R4: A read or write to an idle bank issues an activate carrying the row on sd_addr. The column command follows no sooner than TRCD cycles later, and an activate never targets an open bank.
- R5: A read or write to a bank that is open on another row issues a precharge of that bank only (sd_addr[10] low). An activate of the new row follows no sooner than TRP cycles later.
- R6: A read or write to the row already open in its bank issues the column command directly, with no precharge or activate.
- R7: A refresh request while any bank is open issues one precharge-all (sd_addr[10] high). The refresh follows exactly TRP cycles later.
- R8: A refresh is issued only when all banks are idle. When no bank is open, no precharge precedes it. After it, all banks count as idle, so the next access needs an activate.
- R9: For TRC-1 cycles after a refresh only NOPs are driven. A pending request is issued exactly TRC cycles after the refresh.
- R10: req_ready pulses high for one cycle, in the cycle whose clock edge puts the request's read, write or refresh command on the pins.
- R11: Request code 11 is ignored: req_ready stays low and no command is issued. Codes are 00 read, 01 write, 10 refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until accepted |
| req_op | input | 2 | 00 read, 01 write, 10 refresh, 11 reserved |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ROW_W | Multiplexed row/column address |
| sd_dq_out | output | DATA_W | Write data to device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DATA_W | Read data from device |
| rd_valid | output | 1 | Returned read data valid |
| rd_data | output | DATA_W | Returned read data |

## Verification
A wrong bank-state entry shows up on the pins at the next access to that bank. It appears as an activate to an open bank, a missing activate before a column command, or a spurious precharge, and the bench's device model flags it in that same cycle. A wrong wait count shows up as a gap between precharge, activate, refresh and the next command that is shorter or longer than tRP, tRCD or tRC, measured at the next command. A wrong latency tap misaligns the first returned read, which the scoreboard catches CL+1 cycles after the read command.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // Pin codes are {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DSEL = 4'b1111,
    CMD_NOP  = 4'b0111,
    CMD_ACT  = 4'b0011,
    CMD_RD   = 4'b0101,
    CMD_WR   = 4'b0100,
    CMD_PRE  = 4'b0010,
    CMD_REF  = 4'b0001
  } cmd_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_WR  = 2'b01,
    OP_REF = 2'b10,
    OP_RSV = 2'b11
  } op_e;
endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_seq_pkg::*;
#(
  parameter int NB    = 4,
  parameter int ROW_W = 12,
  localparam int BA_W = $clog2(NB)
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  cmd_e                      cmd,
  input  logic                      all_sel,
  input  logic [BA_W-1:0]           ba,
  input  logic [ROW_W-1:0]          row,
  output logic [NB-1:0]             open_mask,
  output logic [NB-1:0][ROW_W-1:0]  open_rows
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit_bank;
    assign hit_bank = (ba == BA_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_mask[b] <= 1'b0;
        open_rows[b] <= '0;
      end else if (cmd == CMD_ACT && hit_bank) begin
        open_mask[b] <= 1'b1;
        open_rows[b] <= row;
      end else if (cmd == CMD_PRE && (all_sel || hit_bank)) begin
        open_mask[b] <= 1'b0;
      end
    end
  end

  // R4: an activate is only ever aimed at an idle bank
  a_r4_act_idle_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> !open_mask[ba]);
endmodule

// File: rtl/sdram_rd_align.sv
module sdram_rd_align #(
  parameter int CL     = 2,
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [CL-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe[0] <= rd_issue;
      for (int i = 1; i < CL; i++) pipe[i] <= pipe[i-1];
      rd_valid <= pipe[CL-1];
      if (pipe[CL-1]) rd_data <= dq_in;
    end
  end

  // R3: valid strobe trails the read command on the pins by CL+1 cycles
  a_r3_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_issue, CL + 1));
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int CL     = 2,
  parameter int TRP    = 2,
  parameter int TRCD   = 2,
  parameter int TRC    = 6,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(NB)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int MAX_T = (TRC > TRP) ? ((TRC > TRCD) ? TRC : TRCD)
                                     : ((TRP > TRCD) ? TRP : TRCD);
  localparam int CNT_W = $clog2(MAX_T + 1);

  // Column address with the all-banks bit left low
  function automatic logic [ROW_W-1:0] col_field(input logic [COL_W-1:0] c);
    logic [ROW_W-1:0] a;
    a = '0;
    a[COL_W-1:0] = c;
    return a;
  endfunction

  function automatic logic [ROW_W-1:0] all_banks_field();
    logic [ROW_W-1:0] a;
    a = '0;
    a[AP_BIT] = 1'b1;
    return a;
  endfunction

  // Idle cycles to insert after a command so the next lands 'cycles' later
  function automatic logic [CNT_W-1:0] gap(input int cycles);
    return CNT_W'(cycles - 1);
  endfunction

  cmd_e                     cmd_q, nxt_cmd;
  op_e                      op;
  logic [CNT_W-1:0]         wait_cnt, nxt_wait, ref_age;
  logic [ROW_W-1:0]         nxt_addr;
  logic                     nxt_ready;
  logic [NB-1:0]            open_mask;
  logic [NB-1:0][ROW_W-1:0] open_rows;
  logic                     lock_busy, bank_open, bank_hit, any_open;

  assign op        = op_e'(req_op);
  assign lock_busy = (wait_cnt != '0);
  assign any_open  = |open_mask;
  assign bank_open = open_mask[req_bank];
  assign bank_hit  = bank_open && (open_rows[req_bank] == req_row);

  always_comb begin
    nxt_cmd   = CMD_NOP;
    nxt_addr  = '0;
    nxt_wait  = '0;
    nxt_ready = 1'b0;
    if (req_valid && !lock_busy) begin
      unique case (op)
        OP_REF: begin
          if (any_open) begin
            nxt_cmd  = CMD_PRE;
            nxt_addr = all_banks_field();
            nxt_wait = gap(TRP);
          end else begin
            nxt_cmd   = CMD_REF;
            nxt_wait  = gap(TRC);
            nxt_ready = 1'b1;
          end
        end
        OP_RD, OP_WR: begin
          if (!bank_open) begin
            nxt_cmd  = CMD_ACT;
            nxt_addr = req_row;
            nxt_wait = gap(TRCD);
          end else if (!bank_hit) begin
            nxt_cmd  = CMD_PRE;
            nxt_wait = gap(TRP);
          end else begin
            nxt_cmd   = (op == OP_RD) ? CMD_RD : CMD_WR;
            nxt_addr  = col_field(req_col);
            nxt_ready = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign req_ready = nxt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= CMD_DSEL;
      sd_cke    <= 1'b0;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      wait_cnt  <= '0;
    end else begin
      cmd_q     <= nxt_cmd;
      sd_cke    <= 1'b1;
      sd_ba     <= req_bank;
      sd_addr   <= nxt_addr;
      sd_dq_oe  <= (nxt_cmd == CMD_WR);
      if (nxt_cmd == CMD_WR) sd_dq_out <= req_wdata;
      wait_cnt  <= lock_busy ? wait_cnt - 1'b1 : nxt_wait;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  sdram_bank_track #(.NB(NB), .ROW_W(ROW_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (nxt_cmd),
    .all_sel   (nxt_addr[AP_BIT]),
    .ba        (req_bank),
    .row       (nxt_addr),
    .open_mask (open_mask),
    .open_rows (open_rows)
  );

  sdram_rd_align #(.CL(CL), .DATA_W(DATA_W)) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_issue (cmd_q == CMD_RD),
    .dq_in    (sd_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // Checker-side age of the last refresh seen on the pins
  always_ff @(posedge clk) begin
    if (!rst_n)                 ref_age <= CNT_W'(TRC);
    else if (cmd_q == CMD_REF)  ref_age <= CNT_W'(1);
    else if (ref_age < CNT_W'(TRC)) ref_age <= ref_age + 1'b1;
  end

  // R1: clock enable high once out of reset
  a_r1_cke_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sd_cke);

  // R9: inside the refresh window only NOPs reach the pins
  a_r9_trc_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_age < CNT_W'(TRC)) |-> (cmd_q == CMD_NOP));

  // R8: refresh on the pins only while the tracker shows every bank idle
  a_r8_ref_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> (open_mask == '0));

  // R6: column commands only to a bank the tracker holds open
  a_r6_rdwr_open_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> open_mask[sd_ba]);

  // R10: an accepted request shows up as its final command next cycle
  a_r10_ready_issues: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (cmd_q == CMD_RD || cmd_q == CMD_WR || cmd_q == CMD_REF));
endmodule

// File: tb/sdram_cmd_seq_bench.sv
`timescale 1ns/1ps
module sdram_cmd_seq_bench;
  import sdram_seq_pkg::*;
  localparam int CL = 2, TRP = 2, TRCD = 2, TRC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [1:0]  req_bank = '0;
  logic [11:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe, rd_valid;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;
  logic [15:0] sd_dq_out, sd_dq_in, rd_data;

  always #2.5 clk = ~clk;

  sdram_cmd_seq #(.CL(CL), .TRP(TRP), .TRCD(TRCD), .TRC(TRC)) u_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .req_ready(req_ready), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data));

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [21:0] key_of(input int b, input int r, input int c);
    return {b[1:0], r[11:0], c[7:0]};
  endfunction
  function automatic logic [15:0] dflt(input logic [21:0] k);
    return {k[21:20], k[13:8], k[7:0]};
  endfunction

  // ---------------- device model and pin monitor ----------------
  cmd_e        pc;
  assign pc = cmd_e'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});

  logic [15:0] mem [logic [21:0]];
  logic [15:0] shadow [logic [21:0]];
  bit          m_open [4];
  logic [11:0] m_row  [4];
  int last_act [4];
  int last_pre [4];
  int ncyc = 0, last_ref = -1000, last_preall = -1000;
  int n_act = 0, n_pre = 0, n_preall = 0, n_ref = 0, n_any = 0;
  int rd_cyc_q [$];
  logic [15:0] exp_q [$];
  bit          rd_flag = 0;
  logic [15:0] rd_word = '0;
  logic [15:0] dline [CL];

  initial begin
    for (int i = 0; i < 4; i++) begin
      last_act[i] = -1000; last_pre[i] = -1000; m_open[i] = 0; m_row[i] = '0;
    end
    for (int i = 0; i < CL; i++) dline[i] = '0;
  end

  always @(posedge clk) begin
    dline[0] <= rd_flag ? rd_word : 16'h0;
    for (int i = 1; i < CL; i++) dline[i] <= dline[i-1];
  end
  assign sd_dq_in = dline[CL-1];

  always @(negedge clk) begin
    ncyc++;
    rd_flag = 0;
    if (rst_n && !ended) begin
      int b;
      logic [21:0] k;
      b = int'(sd_ba);
      if (pc != CMD_NOP) begin
        n_any++;
        chk(sd_cke === 1'b1, "R1", "cke high on command", 32'(sd_cke), 1);
      end
      case (pc)
        CMD_NOP: ;
        CMD_ACT: begin
          chk(!m_open[b], "R4", "activate to idle bank", 32'(m_open[b]), 0);
          chk(ncyc - last_ref >= TRC, "R9", "refresh to activate gap", ncyc - last_ref, TRC);
          chk(ncyc - last_pre[b] >= TRP, "R5", "precharge to activate gap", ncyc - last_pre[b], TRP);
          m_open[b] = 1; m_row[b] = sd_addr; last_act[b] = ncyc; n_act++;
        end
        CMD_RD, CMD_WR: begin
          chk(m_open[b], "R6", "column cmd to open bank", 32'(m_open[b]), 1);
          chk(ncyc - last_act[b] >= TRCD, "R4", "activate to column gap", ncyc - last_act[b], TRCD);
          chk(sd_addr[10] == 1'b0, "R2", "A10 low on column cmd", 32'(sd_addr[10]), 0);
          k = {sd_ba, m_row[b], sd_addr[7:0]};
          if (pc == CMD_WR) begin
            chk(sd_dq_oe === 1'b1, "R2", "oe with write", 32'(sd_dq_oe), 1);
            mem[k] = sd_dq_out;
          end else begin
            rd_flag = 1;
            rd_word = mem.exists(k) ? mem[k] : dflt(k);
            rd_cyc_q.push_back(ncyc);
          end
        end
        CMD_PRE: begin
          if (sd_addr[10]) begin
            for (int i = 0; i < 4; i++) begin m_open[i] = 0; last_pre[i] = ncyc; end
            last_preall = ncyc; n_preall++;
          end else begin
            m_open[b] = 0; last_pre[b] = ncyc; n_pre++;
          end
        end
        CMD_REF: begin
          chk(!(m_open[0] || m_open[1] || m_open[2] || m_open[3]), "R8",
              "refresh with all banks idle", {m_open[0], m_open[1], m_open[2], m_open[3]}, 0);
          chk(ncyc - last_ref >= TRC, "R9", "refresh to refresh gap", ncyc - last_ref, TRC);
          last_ref = ncyc; n_ref++;
        end
        default: chk(0, "R1", "illegal pin code", 32'(pc), 32'(CMD_NOP));
      endcase
      if (rd_valid) begin
        if (exp_q.size() == 0 || rd_cyc_q.size() == 0) begin
          chk(0, "R3", "unexpected rd_valid", 1, 0);
        end else begin
          logic [15:0] e;
          int t;
          e = exp_q.pop_front();
          t = rd_cyc_q.pop_front();
          chk(rd_data === e, "R3", "read data", 32'(rd_data), 32'(e));
          chk(ncyc - t == CL + 1, "R3", "read latency", ncyc - t, CL + 1);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic do_req(input logic [1:0] op, input int b, input int r, input int c,
                        input logic [15:0] wd);
    logic [21:0] k;
    @(negedge clk);
    req_valid = 1; req_op = op; req_bank = b[1:0]; req_row = r[11:0];
    req_col = c[7:0]; req_wdata = wd;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    k = key_of(b, r, c);
    if (op == OP_RD) exp_q.push_back(shadow.exists(k) ? shadow[k] : dflt(k));
    if (op == OP_WR) shadow[k] = wd;
    @(negedge clk);
    req_valid = 0;
    #1 chk(req_ready == 1'b0, "R10", "ready is a single pulse", 32'(req_ready), 0);
  endtask

  initial begin
    int a0, p0, pa0, r0, any0;
    repeat (3) @(negedge clk);
    #1;
    chk(pc == CMD_DSEL, "R1", "deselect in reset", 32'(pc), 32'(CMD_DSEL));
    chk(sd_cke == 1'b0, "R1", "cke low in reset", 32'(sd_cke), 0);
    chk(rd_valid == 1'b0, "R3", "no valid in reset", 32'(rd_valid), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    #1;
    chk(pc == CMD_NOP, "R1", "idle NOP", 32'(pc), 32'(CMD_NOP));
    chk(sd_cke == 1'b1, "R1", "cke after reset", 32'(sd_cke), 1);

    // R4: idle bank needs an activate
    a0 = n_act; p0 = n_pre;
    do_req(OP_WR, 0, 5, 3, 16'hA5A5);
    chk(n_act == a0 + 1, "R4", "activate before write", n_act - a0, 1);
    // R6: same row hit
    a0 = n_act; p0 = n_pre;
    do_req(OP_RD, 0, 5, 3, 0);
    chk(n_act == a0 && n_pre == p0, "R6", "no row commands on hit", n_act - a0 + n_pre - p0, 0);
    do_req(OP_WR, 1, 7, 9, 16'h1234);
    do_req(OP_RD, 1, 7, 9, 0);
    do_req(OP_RD, 2, 100, 200, 0);
    do_req(OP_WR, 1, 7, 10, 16'hBEEF);
    do_req(OP_RD, 1, 7, 10, 0);
    do_req(OP_RD, 1, 7, 9, 0);
    // R5: row miss
    a0 = n_act; p0 = n_pre;
    do_req(OP_RD, 0, 6, 3, 0);
    chk(n_pre == p0 + 1, "R5", "single-bank precharge on miss", n_pre - p0, 1);
    chk(n_act == a0 + 1, "R5", "activate new row", n_act - a0, 1);
    // R7: refresh with open banks
    pa0 = n_preall; r0 = n_ref;
    do_req(OP_REF, 0, 0, 0, 0);
    chk(n_preall == pa0 + 1, "R7", "precharge-all before refresh", n_preall - pa0, 1);
    chk(n_ref == r0 + 1, "R7", "refresh issued", n_ref - r0, 1);
    chk(last_ref - last_preall == TRP, "R7", "precharge-all to refresh", last_ref - last_preall, TRP);
    // R8/R9: access right after refresh needs activate, exactly TRC later
    a0 = n_act;
    do_req(OP_RD, 0, 5, 3, 0);
    chk(n_act == a0 + 1, "R8", "banks idle after refresh", n_act - a0, 1);
    chk(last_act[0] - last_ref == TRC, "R9", "refresh to activate exact", last_act[0] - last_ref, TRC);
    // R8: refresh twice; second has nothing to close
    do_req(OP_REF, 0, 0, 0, 0);
    pa0 = n_preall; r0 = last_ref;
    do_req(OP_REF, 0, 0, 0, 0);
    chk(n_preall == pa0, "R8", "no precharge when idle", n_preall - pa0, 0);
    chk(last_ref - r0 == TRC, "R9", "refresh to refresh exact", last_ref - r0, TRC);
    // R11: reserved code ignored
    any0 = n_any;
    @(negedge clk);
    req_valid = 1; req_op = 2'b11; req_bank = 2'd3;
    for (int i = 0; i < 12; i++) begin
      #1 chk(req_ready == 1'b0, "R11", "no ready for reserved op", 32'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 0;
    #1 chk(n_any == any0, "R11", "no commands for reserved op", n_any - any0, 0);
    // more traffic across banks
    do_req(OP_WR, 3, 4095, 255, 16'h0F0F);
    do_req(OP_WR, 2, 100, 201, 16'h7777);
    do_req(OP_RD, 3, 4095, 255, 0);
    do_req(OP_RD, 2, 100, 201, 0);
    do_req(OP_RD, 2, 100, 200, 0);
    do_req(OP_RD, 1, 7, 10, 0);
    repeat (20) @(negedge clk);
    #1 chk(exp_q.size() == 0, "R3", "all reads returned", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 0, 1);
    finish_run();
  end
endmodule